// File: doc/BRIEF.md
# Program/Erase Status Read Logic

This block sits between the array read path and the read data bus of a nonvolatile memory. It decides which byte is returned to the host while an embedded program or erase operation is running. An operation begins on a start pulse, which captures the operation kind and the top bit of the byte being programmed. It ends on a done pulse from the operation sequencer, or on the expiry of an optional internal busy timer used for testing. While an operation is busy, each read returns a status byte instead of array contents. Bit 7 is a polling bit that tells a program from an erase. Bit 6 is a toggle bit that changes on every read. Bits 5 to 0 are 0.

When the operation ends, reads pass the array data through unchanged. An abort input cancels a running operation. The block then keeps reporting busy status for a fixed number of clocks before it returns to standby.

The controller has three states. `ST_IDLE` is standby, where reads pass through. `ST_BUSY` means an operation is in progress. `ST_ABORT` is the reset latency after an abort. The transitions are:

- `ST_IDLE` -> `ST_BUSY` on `op_start`.
- `ST_BUSY` -> `ST_IDLE` on `op_done` or on expiry of the internal timer.
- `ST_BUSY` -> `ST_ABORT` on `abort_req`. An abort takes priority over a done in the same cycle.
- `ST_ABORT` -> `ST_IDLE` when the latency counter reaches zero.

Top module: `psr_status_read`

## Requirements
- R1: After `rst_n` is released the block is idle: `busy` is 0 and `rd_data` equals `array_data`.
- R2: While a program operation is busy (`op_kind` = 0 at start), bit 7 of `rd_data` is the inverse of the `prog_msb` value captured at the start.
- R3: While an erase operation is busy (`op_kind` = 1 at start), bit 7 of `rd_data` is 0.
- R4: Bit 6 of `rd_data` is 0 on the first read after a start. It inverts after every clock in which `rd_strobe` is 1 while busy, and holds its value in busy clocks without `rd_strobe`.
- R5: While busy, bits 5 to 0 of `rd_data` are 0.
- R6: An `op_done` pulse while busy returns the block to idle on the next clock. From then on `rd_data` equals `array_data` and stops toggling. An `op_done` while idle has no effect.
- R7: An `abort_req` while busy keeps `busy` high with status reporting for exactly `RST_LAT` clocks after the clock that samples it, then returns to idle. An `abort_req` while idle has no effect.
- R8: With `use_timer` = 1, an operation ends by itself after `BUSY_CYC` busy clocks with no `op_done`.
- R9: An `op_start` while busy is ignored. The captured kind, the captured data bit and the toggle bit keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| op_start | input | 1 | Pulse: an embedded operation begins |
| op_kind | input | 1 | Kind of the starting operation, 0 program, 1 erase |
| prog_msb | input | 1 | Bit 7 of the last byte loaded for programming |
| op_done | input | 1 | Pulse: the embedded operation has completed |
| abort_req | input | 1 | Abort the running operation |
| use_timer | input | 1 | Let the internal busy timer end operations |
| rd_strobe | input | 1 | A read of the device occurs in this clock |
| array_data | input | 8 | Data read from the array |
| rd_data | output | 8 | Byte returned to the reader |
| busy | output | 1 | An operation or abort latency is in progress |

## Verification
The assertions check the following on every cycle:

- The state transitions on done and abort.
- The per-read inversion and the hold of the toggle bit.
- That a start while busy leaves the captured operation unchanged.
- That the internal counter stays in range.

Only the bench's scenarios can show the end-to-end values:

- The polling bit for each kind and captured data value.
- The toggle sequence over several reads.
- The exact clock counts of the abort latency and the internal timer.
- The return to true array data after each kind of completion.

// File: rtl/psr_pkg.sv
package psr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_ABORT = 2'd2
    } psr_state_e;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } psr_kind_e;

    localparam int STATUS_POLL_BIT = 7;
    localparam int STATUS_TOG_BIT  = 6;

endpackage

// File: rtl/psr_fsm.sv
module psr_fsm
    import psr_pkg::*;
#(
    parameter int RST_LAT = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      op_start,
    input  logic      done_evt,
    input  logic      abort_req,
    input  logic      op_kind,
    input  logic      prog_msb,
    output logic      busy,
    output logic      running,
    output logic      start_acc,
    output psr_kind_e kind_q,
    output logic      msb_q
);
    localparam int LW = $clog2(RST_LAT + 1);

    psr_state_e state_q, state_d;
    logic [LW-1:0] lat_q;
    logic          lat_zero;

    assign lat_zero = (lat_q == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (op_start)       state_d = ST_BUSY;
            ST_BUSY:  if (abort_req)      state_d = ST_ABORT;
                      else if (done_evt)  state_d = ST_IDLE;
            ST_ABORT: if (lat_zero)       state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        running   = 1'b0;
        start_acc = 1'b0;
        unique case (state_q)
            ST_IDLE:  start_acc = op_start;
            ST_BUSY:  begin busy = 1'b1; running = 1'b1; end
            ST_ABORT: busy = 1'b1;
            default:  ;
        endcase
    end

    // captured operation and abort latency counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= OP_PROGRAM;
            msb_q  <= 1'b0;
            lat_q  <= '0;
        end else begin
            if (start_acc) begin
                kind_q <= psr_kind_e'(op_kind);
                msb_q  <= prog_msb;
            end
            if (state_q == ST_BUSY && abort_req)
                lat_q <= LW'(RST_LAT - 1);
            else if (state_q == ST_ABORT && !lat_zero)
                lat_q <= lat_q - 1'b1;
        end
    end

    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && done_evt && !abort_req) |=> (state_q == ST_IDLE));

    a_r7_abort_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && abort_req) |=> (state_q == ST_ABORT));

    a_r7_idle_abort_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !op_start) |=> (state_q == ST_IDLE));

    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_start) |=> ($stable(kind_q) && $stable(msb_q)));

endmodule

// File: rtl/psr_toggle.sv
module psr_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic start_acc,
    input  logic busy,
    input  logic rd_strobe,
    output logic tog_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)                tog_q <= 1'b0;
        else if (start_acc)        tog_q <= 1'b0;
        else if (busy && rd_strobe) tog_q <= ~tog_q;
    end

    a_r4_flip_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_strobe) |=> (tog_q != $past(tog_q)));

    a_r4_hold_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_strobe) |=> $stable(tog_q));

endmodule

// File: rtl/psr_timer.sv
module psr_timer #(
    parameter int BUSY_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_acc,
    input  logic running,
    input  logic enable,
    output logic expire
);
    localparam int TW = $clog2(BUSY_CYC + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (start_acc)             cnt_q <= TW'(BUSY_CYC - 1);
        else if (running && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign expire = enable && running && (cnt_q == '0);

    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TW'(BUSY_CYC - 1));

endmodule

// File: rtl/psr_status_read.sv
module psr_status_read
    import psr_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int RST_LAT  = 4,
    parameter int BUSY_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic              op_kind,
    input  logic              prog_msb,
    input  logic              op_done,
    input  logic              abort_req,
    input  logic              use_timer,
    input  logic              rd_strobe,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);
    psr_kind_e kind_q;
    logic      msb_q, running, start_acc, tog_q, expire, done_evt;

    assign done_evt = op_done | expire;

    psr_fsm #(.RST_LAT(RST_LAT)) i_fsm (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .done_evt(done_evt),
        .abort_req(abort_req), .op_kind(op_kind), .prog_msb(prog_msb),
        .busy(busy), .running(running), .start_acc(start_acc),
        .kind_q(kind_q), .msb_q(msb_q)
    );

    psr_toggle i_tog (
        .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .busy(busy),
        .rd_strobe(rd_strobe), .tog_q(tog_q)
    );

    psr_timer #(.BUSY_CYC(BUSY_CYC)) i_tmr (
        .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .running(running),
        .enable(use_timer), .expire(expire)
    );

    always_comb begin
        rd_data = array_data;
        if (busy) begin
            rd_data                  = '0;
            rd_data[STATUS_POLL_BIT] = (kind_q == OP_ERASE) ? 1'b0 : ~msb_q;
            rd_data[STATUS_TOG_BIT]  = tog_q;
        end
    end

    a_r3_erase_poll_low: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && kind_q == OP_ERASE) |-> !rd_data[STATUS_POLL_BIT]);

    a_r5_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rd_data[5:0] == '0));

endmodule

// File: tb/test_psr_status_read.sv
module test_psr_status_read;
    localparam int CLK_P    = 10;
    localparam int RST_LAT  = 4;
    localparam int BUSY_CYC = 16;

    typedef struct packed {
        logic       kind;
        logic       msb;
        logic [7:0] arr;
        logic [3:0] nrd;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b1, 8'hA5, 4'd3},
        '{1'b0, 1'b0, 8'h3C, 4'd4},
        '{1'b1, 1'b0, 8'hFF, 4'd5},
        '{1'b1, 1'b1, 8'hFF, 4'd2},
        '{1'b0, 1'b1, 8'h00, 4'd1},
        '{1'b1, 1'b0, 8'h7E, 4'd6}
    };

    logic clk = 0, rst_n = 0, op_start = 0, op_kind = 0, prog_msb = 0;
    logic op_done = 0, abort_req = 0, use_timer = 0, rd_strobe = 0;
    logic [7:0] array_data = 8'h00, rd_data;
    logic busy;
    int checks = 0, errors = 0;

    always #(CLK_P/2) clk = ~clk;

    psr_status_read #(.RST_LAT(RST_LAT), .BUSY_CYC(BUSY_CYC)) i_psr_status_read (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .prog_msb(prog_msb), .op_done(op_done), .abort_req(abort_req),
        .use_timer(use_timer), .rd_strobe(rd_strobe), .array_data(array_data),
        .rd_data(rd_data), .busy(busy)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic start_op(input logic k, input logic m);
        @(negedge clk);
        op_kind = k; prog_msb = m; op_start = 1;
        @(negedge clk);
        op_start = 0;
    endtask

    task automatic pulse_done;
        op_done = 1;
        @(negedge clk);
        op_done = 0;
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        array_data = 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 busy after reset", {7'd0, busy}, 8'h00);
        chk("R1 passthrough", rd_data, 8'h5A);

        // vector table: R2 R3 R4 R5 R6
        foreach (VECS[v]) begin
            array_data = VECS[v].arr;
            start_op(VECS[v].kind, VECS[v].msb);
            for (int r = 0; r < int'(VECS[v].nrd); r++) begin
                rd_strobe = 1;
                #1;
                chk("R2/R3/R4/R5 status", rd_data,
                    {(VECS[v].kind ? 1'b0 : ~VECS[v].msb), r[0], 6'd0});
                @(negedge clk);
            end
            rd_strobe = 0;
            pulse_done();
            rd_strobe = 1;
            #1;
            chk("R6 true data after done", rd_data, VECS[v].arr);
            @(negedge clk);
            chk("R6 no toggle after done", rd_data, VECS[v].arr);
            rd_strobe = 0;
        end

        // R4: no read, no flip
        start_op(1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R4 hold without read", rd_data, 8'h80);
        rd_strobe = 1; @(negedge clk); rd_strobe = 0;
        repeat (2) @(negedge clk);
        chk("R4 single flip", rd_data, 8'hC0);

        // R9: start while busy ignored
        op_start = 1; op_kind = 1; prog_msb = 1;
        @(negedge clk);
        op_start = 0;
        chk("R9 restart ignored", rd_data, 8'hC0);
        pulse_done();
        chk("R6 done returns idle", {7'd0, busy}, 8'h00);

        // R6: done while idle ignored
        pulse_done();
        chk("R6 idle done ignored", {7'd0, busy}, 8'h00);

        // R7: abort while idle ignored
        abort_req = 1; @(negedge clk); abort_req = 0;
        chk("R7 idle abort ignored", {7'd0, busy}, 8'h00);

        // R7: abort latency
        start_op(1'b1, 1'b0);
        rd_strobe = 1; @(negedge clk); rd_strobe = 0;
        abort_req = 1;
        @(negedge clk);
        abort_req = 0;
        for (int c = 0; c < RST_LAT; c++) begin
            chk("R7 busy during latency", {7'd0, busy}, 8'h01);
            if (c == 0) chk("R7 status in latency", rd_data, 8'h40);
            @(negedge clk);
        end
        chk("R7 idle after latency", {7'd0, busy}, 8'h00);
        chk("R7 passthrough after abort", rd_data, array_data);

        // R8: internal timer
        use_timer = 1;
        @(negedge clk);
        op_kind = 0; prog_msb = 1; op_start = 1;
        @(negedge clk);
        op_start = 0;
        for (int c = 0; c < BUSY_CYC - 1; c++) @(negedge clk);
        chk("R8 busy at last timer clock", {7'd0, busy}, 8'h01);
        @(negedge clk);
        chk("R8 idle after timer", {7'd0, busy}, 8'h00);
        use_timer = 0;

        // R1: reset during operation
        start_op(1'b0, 1'b0);
        rst_n = 0; @(negedge clk); rst_n = 1;
        chk("R1 reset clears busy", {7'd0, busy}, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule